// File: doc/BRIEF.md
# Four-Lane Neighbourhood Read Scheduler

This block sits in front of a two-dimensional Haar kernel. A square image of N = 2^LOG_N coefficients, side W = 2^(LOG_N/2), arrives one word per clock on a write port. Words arrive in natural raster order, so index = row*W + col. Once the last word of the vector has been accepted, the block reads the stored image back as a stream of 2x2 neighbourhoods. It delivers one neighbourhood of four coefficients per clock, which is what the kernel consumes.

Read addresses are not held in a table. A group counter is split into a row index and a column index with a variable right shift (the floor) and a mask. The storage is split into four banks chosen by the low row bit and the low column bit. Because of that split, the four words of a neighbourhood always sit in different banks at the same bank address. A level input shrinks the active region to the top-left (W >> level) square. This lets the same block serve each stage of a multilevel decomposition.

Top module: `quad_read_sched`

## Requirements
- R1: After reset, `load_rdy` is 1 and `busy`, `grp_valid` and `done` are 0.
- R2: While `load_rdy` is 1, each cycle with `wr_valid` high stores `wr_data` at the next natural index, starting at 0. After the edge that accepts index N-1, `load_rdy` is 0 and `busy` is 1 in the following cycle.
- R3: A `wr_valid` pulse while `load_rdy` is 0 is ignored. It neither stores data nor advances the write index.
- R4: Each output group for row index r and column index c holds four lanes in `grp_data`. Lane 0 (bits DW-1:0) is index (2r)W+2c. Lane 1 is (2r)W+2c+1. Lane 2 is (2r+1)W+2c. Lane 3 is (2r+1)W+2c+1.
- R5: Groups come out in row-major order of (r, c). With H = (W/2) >> level, group g has r = floor(g/H) and c = g mod H.
- R6: The read phase emits exactly H*H groups. A `level` above LOG_N/2-1 is treated as LOG_N/2-1, which gives a single group.
- R7: `grp_valid` is high on consecutive cycles with no gap for the whole read phase, and only while `busy` is 1.
- R8: `done` is a one-cycle pulse in the cycle right after the last `grp_valid`. In that cycle `load_rdy` is 1 and `busy` is 0.
- R9: `level` is sampled on the edge that accepts index N-1. Later changes have no effect on the read phase in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe for one coefficient |
| wr_data | input | DW | Coefficient value |
| level | input | LVW | Decomposition level; active side is W >> level |
| load_rdy | output | 1 | Block accepts writes |
| busy | output | 1 | Read phase in progress |
| grp_valid | output | 1 | `grp_data` holds a valid neighbourhood |
| grp_data | output | 4*DW | Four coefficients of one 2x2 neighbourhood |
| done | output | 1 | One-cycle pulse after the last group |

## Verification
The assertions guard the handshake on every cycle. They check that valid appears only inside the busy window, that valid falls only together with the done pulse, that done lasts one cycle and comes right after a valid cycle, and that a rejected write leaves the write index unchanged. They also check that the sampled level stays fixed while busy and that every issued row index lies inside the active square. The shuffle itself can only be shown by the bench scenarios. These compare each group against neighbourhoods built from known images at several levels, including a clamped level. They also show that stray writes and level changes during a read leave the next frame intact and the group count correct.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    localparam int unsigned LANES = 4;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_READ  = 2'd1,
        ST_DRAIN = 2'd2
    } qrs_state_e;

endpackage

// File: rtl/qrs_bank.sv
module qrs_bank #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/qrs_addr_gen.sv
module qrs_addr_gen #(
    parameter int unsigned LOG_HW = 3,
    parameter int unsigned LVW    = 3
) (
    input  logic [2*LOG_HW-1:0] grp,
    input  logic [LVW-1:0]      lvl,
    output logic [LOG_HW-1:0]   row,
    output logic [LOG_HW-1:0]   col,
    output logic [2*LOG_HW-1:0] raddr,
    output logic                last
);
    localparam int unsigned GW = 2 * LOG_HW;

    int unsigned     sh;
    logic [GW:0]     span_w;
    logic [GW:0]     mask_w;

    always_comb begin
        // active half-side is 2^sh groups per row
        sh     = LOG_HW - int'(lvl);
        span_w = (GW+1)'(1) << (2 * sh);
        mask_w = ((GW+1)'(1) << sh) - (GW+1)'(1);
        row    = LOG_HW'(grp >> sh);
        col    = LOG_HW'(grp & mask_w[GW-1:0]);
        raddr  = {row, col};
        last   = ({1'b0, grp} == (span_w - (GW+1)'(1)));
    end

endmodule

// File: rtl/qrs_ctrl.sv
module qrs_ctrl
    import qrs_pkg::*;
#(
    parameter int unsigned LOG_N = 8,
    parameter int unsigned LVW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [LVW-1:0]   level,
    input  logic             last,
    output logic             wr_en,
    output logic [LOG_N-1:0] wcnt,
    output logic             rd_en,
    output logic [LOG_N-3:0] grp,
    output logic [LVW-1:0]   lvl_eff,
    output logic             load_rdy,
    output logic             busy,
    output logic             grp_valid,
    output logic             done
);
    localparam int unsigned LOG_W  = LOG_N / 2;
    localparam int unsigned LOG_HW = LOG_W - 1;
    localparam int unsigned GW     = LOG_N - 2;
    localparam logic [LOG_N-1:0] WLAST = {LOG_N{1'b1}};
    localparam logic [LVW-1:0]   LMAX  = LVW'(LOG_HW);

    typedef struct packed {
        qrs_state_e       st;
        logic [LOG_N-1:0] wcnt;
        logic [GW-1:0]    grp;
        logic [LVW-1:0]   lvl;
        logic             vld;
        logic             dn;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.dn  = 1'b0;
        case (s_q.st)
            ST_LOAD: begin
                if (wr_valid) begin
                    s_d.wcnt = s_q.wcnt + LOG_N'(1);
                    if (s_q.wcnt == WLAST) begin
                        s_d.st  = ST_READ;
                        s_d.grp = '0;
                        s_d.lvl = (level > LMAX) ? LMAX : level;
                    end
                end
            end
            ST_READ: begin
                s_d.vld = 1'b1;
                if (last) begin
                    s_d.st = ST_DRAIN;
                end else begin
                    s_d.grp = s_q.grp + GW'(1);
                end
            end
            ST_DRAIN: begin
                s_d.dn = 1'b1;
                s_d.st = ST_LOAD;
            end
            default: begin
                s_d.st = ST_LOAD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_LOAD, wcnt: '0, grp: '0, lvl: '0, vld: 1'b0, dn: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign load_rdy  = (s_q.st == ST_LOAD);
    assign busy      = (s_q.st != ST_LOAD);
    assign wr_en     = load_rdy && wr_valid;
    assign rd_en     = (s_q.st == ST_READ);
    assign wcnt      = s_q.wcnt;
    assign grp       = s_q.grp;
    assign lvl_eff   = s_q.lvl;
    assign grp_valid = s_q.vld;
    assign done      = s_q.dn;

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_rdy && wr_valid) |=> $stable(s_q.wcnt)); // R3
    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> busy); // R7
    AST_VALID_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grp_valid) |-> done); // R7
    AST_DONE_AFTER_GRP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(grp_valid)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_LEVEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(s_q.lvl)); // R9

endmodule

// File: rtl/quad_read_sched.sv
module quad_read_sched
    import qrs_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned LOG_N = 8,
    parameter int unsigned LVW   = $clog2(LOG_N / 2) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [DW-1:0]        wr_data,
    input  logic [LVW-1:0]       level,
    output logic                 load_rdy,
    output logic                 busy,
    output logic                 grp_valid,
    output logic [4*DW-1:0]      grp_data,
    output logic                 done
);
    localparam int unsigned LOG_W  = LOG_N / 2;
    localparam int unsigned LOG_HW = LOG_W - 1;
    localparam int unsigned BAW    = LOG_N - 2;

    logic             wr_en;
    logic [LOG_N-1:0] wcnt;
    logic             rd_en;
    logic [BAW-1:0]   grp;
    logic [LVW-1:0]   lvl_eff;
    logic             last;
    logic [LOG_HW-1:0] rd_row;
    logic [LOG_HW-1:0] rd_col;
    logic [BAW-1:0]   rd_addr;
    logic [1:0]       wbank;
    logic [BAW-1:0]   waddr;

    qrs_ctrl #(
        .LOG_N (LOG_N),
        .LVW   (LVW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .level     (level),
        .last      (last),
        .wr_en     (wr_en),
        .wcnt      (wcnt),
        .rd_en     (rd_en),
        .grp       (grp),
        .lvl_eff   (lvl_eff),
        .load_rdy  (load_rdy),
        .busy      (busy),
        .grp_valid (grp_valid),
        .done      (done)
    );

    qrs_addr_gen #(
        .LOG_HW (LOG_HW),
        .LVW    (LVW)
    ) u_addr (
        .grp   (grp),
        .lvl   (lvl_eff),
        .row   (rd_row),
        .col   (rd_col),
        .raddr (rd_addr),
        .last  (last)
    );

    // bank = {row lsb, col lsb}; bank address = {row >> 1, col >> 1}
    assign wbank = {wcnt[LOG_W], wcnt[0]};
    assign waddr = {wcnt[LOG_N-1:LOG_W+1], wcnt[LOG_W-1:1]};

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        qrs_bank #(
            .DW (DW),
            .AW (BAW)
        ) u_bank (
            .clk   (clk),
            .we    (wr_en && (wbank == 2'(b))),
            .waddr (waddr),
            .wdata (wr_data),
            .re    (rd_en),
            .raddr (rd_addr),
            .rdata (grp_data[b*DW +: DW])
        );
    end

    AST_ROW_IN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_row) < (1 << (LOG_HW - int'(lvl_eff))))); // R6
    AST_COL_IN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_col) < (1 << (LOG_HW - int'(lvl_eff))))); // R5

endmodule

// File: tb/tb_quad_read_sched.sv
`timescale 1ns/1ps
module tb_quad_read_sched;
    localparam int DW    = 16;
    localparam int LOG_N = 8;
    localparam int LOG_W = LOG_N / 2;
    localparam int N     = 1 << LOG_N;
    localparam int W     = 1 << LOG_W;
    localparam int LVW   = $clog2(LOG_W) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DW-1:0]     wr_data = '0;
    logic [LVW-1:0]    level = '0;
    logic              load_rdy, busy, grp_valid, done;
    logic [4*DW-1:0]   grp_data;

    quad_read_sched #(.DW(DW), .LOG_N(LOG_N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .level(level), .load_rdy(load_rdy), .busy(busy),
        .grp_valid(grp_valid), .grp_data(grp_data), .done(done)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [DW-1:0]   img [N];
    logic [4*DW-1:0] exp_q [$];
    int exp_groups = 0;
    int vcount = 0;
    int frames_done = 0;
    bit prev_valid = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, expv);
        end
    endtask

    // monitor: pops expected neighbourhoods as the design emits them
    always @(negedge clk) begin
        if (rst_n) begin
            if (grp_valid) begin
                chk(busy, "R7 valid outside busy", 64'(busy), 64'd1);
                if (vcount > 0)
                    chk(prev_valid, "R7 gap in group stream", 64'(prev_valid), 64'd1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected extra group", 64'(grp_data), 64'd0);
                end else begin
                    logic [4*DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(grp_data == e, "R4 group data", 64'(grp_data), 64'(e));
                end
                vcount++;
            end
            if (done) begin
                chk(prev_valid, "R8 done not after last group", 64'(prev_valid), 64'd1);
                chk(load_rdy && !busy, "R8 rdy/busy at done", {62'd0, load_rdy, busy}, 64'd2);
                chk(vcount == exp_groups, "R6 group count", 64'(vcount), 64'(exp_groups));
                vcount = 0;
                frames_done++;
            end
            prev_valid = grp_valid;
        end
    end

    // driver: writes one frame and pushes the expected groups
    task automatic load_frame(input int seed, input int lvl);
        int le, h;
        le = (lvl > LOG_W - 1) ? LOG_W - 1 : lvl;
        h  = (W / 2) >> le;
        for (int a = 0; a < N; a++) begin
            @(negedge clk);
            if (a == 3)
                chk(load_rdy && !busy, "R2 ready during load", {62'd0, load_rdy, busy}, 64'd2);
            img[a]   = DW'((a * 37 + seed * 101) ^ (a << 7));
            wr_valid = 1'b1;
            wr_data  = img[a];
            level    = LVW'(lvl);
        end
        exp_groups = h * h;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < h; c++) begin
                int b;
                b = 2 * r * W + 2 * c;
                exp_q.push_back({img[b + W + 1], img[b + W], img[b + 1], img[b]});
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
        chk(!load_rdy && busy, "R2 busy after last write", {62'd0, load_rdy, busy}, 64'd1);
    endtask

    task automatic wait_done();
        int n0, t;
        n0 = frames_done;
        t  = 0;
        while (frames_done == n0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(frames_done != n0, "R8 done never seen", 64'(t), 64'd0);
        chk(exp_q.size() == 0, "R5 groups missing", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired act 1 exp 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(load_rdy && !busy && !grp_valid && !done, "R1 reset state",
            {60'd0, load_rdy, busy, grp_valid, done}, 64'h8);

        // full image, level 0
        load_frame(1, 0);
        wait_done();

        // level 1, with stray writes and a level change while busy
        load_frame(2, 1);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            wr_valid = 1'b1;
            wr_data  = 16'hDEAD;
            level    = '0;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wait_done();

        // level 2 frame: would be misaligned if stray writes had been taken (R3, R9)
        load_frame(3, 2);
        wait_done();

        // out-of-range level clamps to one group
        load_frame(4, 7);
        wait_done();

        @(negedge clk);
        chk(!grp_valid && !done && load_rdy, "R8 idle after frames",
            {61'd0, grp_valid, done, load_rdy}, 64'd1);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule